// File: doc/BRIEF.md
# Consecutive-Identical-Digit Jitter Pattern Generator

This block produces an endless serial test stream for checking how well a SONET/SDH-style receiver tolerates long runs of identical digits. A single period has six segments: 72 ones, a PRBS7 section, a synthesized first row of section overhead, 72 zeros, a second PRBS7 section and the overhead row again. After that the period starts over. When the enable input is high, one bit is emitted per clock.

Several inputs select the variant. They set the overhead row width (n = 48 or n = 192 bytes per framing group), the PRBS section length in bits and the trace byte that heads the growth field. They also choose whether the PRBS continues from one random section into the next or restarts from a seed in each one. The block latches these inputs only on the first bit of each period, so the settings never change partway through a period. A segment identifier and a segment-start strobe come out next to the data bit, which lets a downstream checker align to the pattern.

Top module: `cid_pattern_gen`

## Requirements
- R1: Segments run in the order ones (id 0), random (id 1), overhead (id 2), zeros (id 3), random (id 4), overhead (id 5), and then return to id 0. `seg_id` gives the segment of the bit now on `bit_out`. `seg_start` is high only for the first bit of a segment.
- R2: The ones segment is 72 bits of 1. The zeros segment is 72 bits of 0.
- R3: A random segment bit is stage 7 (the MSB) of a 7-bit register. On every random bit the register shifts left, and the new LSB is the XOR of stages 7 and 6, which gives the polynomial 1 + x^6 + x^7.
- R4: Each random segment is `cfg_rnd_len` bits long. Any value below 2000 is treated as 2000.
- R5: An overhead segment is 3n bytes sent MSB first: n bytes of 0xF6, then n bytes of 0x28, then n/3 growth-field bytes, then 2n/3 bytes of 0xAA. n is 192 when `cfg_wide`=1 and 48 when it is 0.
- R6: The first growth-field byte is `cfg_trace`. The remaining growth-field bytes are 0xCC.
- R7: When `cfg_free_run`=1, the PRBS register carries its state from one random segment into the next, and it starts from 7'h7F after reset. When `cfg_free_run`=0, the register loads the seed at the first bit of every random segment, so that bit is seed[6]. A seed of 0 is replaced by 7'h7F.
- R8: While `en` is low, `bit_out`, `seg_id` and `seg_start` keep their values and the pattern position does not move.
- R9: While reset is asserted, all three outputs are 0. The first enabled bit after reset is the first bit of the ones segment, with `seg_start` high.
- R10: Configuration inputs are latched only at the first bit of the ones segment. A change at any other time has no effect until the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| en | input | 1 | Advance the pattern by one bit |
| cfg_wide | input | 1 | Overhead width select: 0 gives n=48, 1 gives n=192 |
| cfg_rnd_len | input | 16 | Random segment length in bits (minimum 2000) |
| cfg_trace | input | 8 | First growth-field byte |
| cfg_free_run | input | 1 | 1 = PRBS continues across segments, 0 = reload seed |
| cfg_seed | input | 7 | PRBS seed for reload mode |
| bit_out | output | 1 | Pattern bit |
| seg_start | output | 1 | High on the first bit of a segment |
| seg_id | output | 3 | Segment identifier of the current bit |

## Verification
Every output is registered. A bit, its segment id and its start flag all appear after the same rising edge at which `en` is sampled high, so the latency is one cycle. After `rst_n` rises, two more clocks pass inside the synchronizer before `en` is obeyed. The bench changes inputs on the falling edge and reads outputs on the next falling edge. For each enabled cycle its reference model computes the bit, id and start flag. For each disabled cycle it expects the previous values to hold. Configuration changes are made in the middle of a period, which checks that they only take effect at the next ones segment.

// File: rtl/cid_pkg.sv
package cid_pkg;

  typedef enum logic [2:0] {
    SEG_ONES  = 3'd0,
    SEG_RND1  = 3'd1,
    SEG_OH1   = 3'd2,
    SEG_ZEROS = 3'd3,
    SEG_RND2  = 3'd4,
    SEG_OH2   = 3'd5
  } seg_e;

  localparam int        RUN_BITS   = 72;
  localparam logic [7:0] FRAME_HI  = 8'hF6;
  localparam logic [7:0] FRAME_LO  = 8'h28;
  localparam logic [7:0] GROWTH    = 8'hCC;
  localparam logic [7:0] FILLER    = 8'hAA;

  function automatic seg_e seg_next(seg_e s);
    case (s)
      SEG_ONES:  return SEG_RND1;
      SEG_RND1:  return SEG_OH1;
      SEG_OH1:   return SEG_ZEROS;
      SEG_ZEROS: return SEG_RND2;
      SEG_RND2:  return SEG_OH2;
      default:   return SEG_ONES;
    endcase
  endfunction

  function automatic logic [6:0] prbs7_step(logic [6:0] s);
    return {s[5:0], s[6] ^ s[5]};
  endfunction

endpackage

// File: rtl/cid_rst_sync.sv
module cid_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = chain_q[STAGES-1];
endmodule

// File: rtl/cid_prbs7.sv
module cid_prbs7 import cid_pkg::*; #(
  parameter logic [6:0] INIT = 7'h7F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic       reload,
  input  logic [6:0] seed,
  output logic       bit_o
);
  logic [6:0] st_q, st_d, src;

  always_comb begin
    src   = reload ? seed : st_q;
    bit_o = src[6];
    st_d  = adv ? prbs7_step(src) : st_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= INIT;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/cid_ohrow.sv
module cid_ohrow import cid_pkg::*; #(
  parameter int N_SMALL = 48,
  parameter int N_LARGE = 192,
  parameter int IDX_W   = 16
) (
  input  logic             wide,
  input  logic [7:0]       trace,
  input  logic [IDX_W-1:0] idx,
  output logic             bit_o
);
  localparam int BYTE_W = IDX_W - 3;

  logic [BYTE_W-1:0] byte_i;
  logic [2:0]        pos;
  logic [7:0]        cur;
  int                n_b, b;

  assign byte_i = idx[IDX_W-1:3];
  assign pos    = idx[2:0];

  always_comb begin
    n_b = wide ? N_LARGE : N_SMALL;
    b   = int'(byte_i);
    if (b < n_b)                     cur = FRAME_HI;
    else if (b < 2 * n_b)            cur = FRAME_LO;
    else if (b == 2 * n_b)           cur = trace;
    else if (b < 2 * n_b + n_b / 3)  cur = GROWTH;
    else                             cur = FILLER;
    bit_o = cur[3'd7 - pos];
  end
endmodule

// File: rtl/cid_pattern_gen.sv
module cid_pattern_gen import cid_pkg::*; #(
  parameter int         LEN_W    = 16,
  parameter int         N_SMALL  = 48,
  parameter int         N_LARGE  = 192,
  parameter int         MIN_RND  = 2000,
  parameter int         DEF_RND  = 10000,
  parameter logic [6:0] DEF_SEED = 7'h7F,
  parameter logic [7:0] DEF_J0   = 8'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             cfg_wide,
  input  logic [LEN_W-1:0] cfg_rnd_len,
  input  logic [7:0]       cfg_trace,
  input  logic             cfg_free_run,
  input  logic [6:0]       cfg_seed,
  output logic             bit_out,
  output logic             seg_start,
  output logic [2:0]       seg_id
);
  localparam logic [LEN_W-1:0] RUN_LEN = LEN_W'(RUN_BITS);
  localparam logic [LEN_W-1:0] OH_SML  = LEN_W'(24 * N_SMALL);
  localparam logic [LEN_W-1:0] OH_LRG  = LEN_W'(24 * N_LARGE);
  localparam logic [LEN_W-1:0] RND_MIN = LEN_W'(MIN_RND);

  logic rst_s_n;

  cid_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n));

  // sequencer and latched configuration
  seg_e             seg_q, seg_d;
  logic [LEN_W-1:0] cnt_q, cnt_d, seg_len, len_q, len_d;
  logic             wide_q, free_q;
  logic [7:0]       trace_q;
  logic [6:0]       seed_q, seed_d;
  logic             at_top, take_cfg, seg_last, is_rnd, cur_bit;
  logic             rnd_bit, oh_bit;
  logic             bit_q, start_q;
  logic [2:0]       id_q;

  always_comb begin
    at_top   = (seg_q == SEG_ONES) && (cnt_q == '0);
    take_cfg = en && at_top;
    len_d    = (cfg_rnd_len < RND_MIN) ? RND_MIN : cfg_rnd_len;
    seed_d   = (cfg_seed == 7'd0) ? 7'h7F : cfg_seed;
    is_rnd   = (seg_q == SEG_RND1) || (seg_q == SEG_RND2);
    case (seg_q)
      SEG_ONES, SEG_ZEROS: seg_len = RUN_LEN;
      SEG_RND1, SEG_RND2:  seg_len = len_q;
      default:             seg_len = wide_q ? OH_LRG : OH_SML;
    endcase
    seg_last = (cnt_q == seg_len - 1'b1);
    case (seg_q)
      SEG_ONES:           cur_bit = 1'b1;
      SEG_ZEROS:          cur_bit = 1'b0;
      SEG_RND1, SEG_RND2: cur_bit = rnd_bit;
      default:            cur_bit = oh_bit;
    endcase
    seg_d = seg_q;
    cnt_d = cnt_q;
    if (en) begin
      if (seg_last) begin
        seg_d = seg_next(seg_q);
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  cid_prbs7 #(.INIT(7'h7F)) u_prbs (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .adv    (en && is_rnd),
    .reload (!free_q && (cnt_q == '0)),
    .seed   (seed_q),
    .bit_o  (rnd_bit)
  );

  cid_ohrow #(.N_SMALL(N_SMALL), .N_LARGE(N_LARGE), .IDX_W(LEN_W)) u_oh (
    .wide  (wide_q),
    .trace (trace_q),
    .idx   (cnt_q),
    .bit_o (oh_bit)
  );

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      seg_q <= SEG_ONES;
      cnt_q <= '0;
    end else begin
      seg_q <= seg_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      wide_q  <= 1'b0;
      len_q   <= LEN_W'(DEF_RND);
      trace_q <= DEF_J0;
      free_q  <= 1'b1;
      seed_q  <= DEF_SEED;
    end else if (take_cfg) begin
      wide_q  <= cfg_wide;
      len_q   <= len_d;
      trace_q <= cfg_trace;
      free_q  <= cfg_free_run;
      seed_q  <= seed_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      bit_q   <= 1'b0;
      start_q <= 1'b0;
      id_q    <= 3'd0;
    end else if (en) begin
      bit_q   <= cur_bit;
      start_q <= (cnt_q == '0);
      id_q    <= seg_q;
    end
  end

  assign bit_out   = bit_q;
  assign seg_start = start_q;
  assign seg_id    = id_q;
endmodule

// File: rtl/cid_pattern_chk.sv
module cid_pattern_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       bit_out,
  input logic       seg_start,
  input logic [2:0] seg_id
);
  logic live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  live_q <= 1'b0;
    else if (en) live_q <= 1'b1;
  end

  a_r2_ones_run: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && seg_id == 3'd0) |-> bit_out);

  a_r2_zeros_run: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_id == 3'd3) |-> !bit_out);

  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(bit_out) && $stable(seg_id) && $stable(seg_start)));

  a_r1_id_moves_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(seg_id) |-> seg_start);

  a_r1_segment_order: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(seg_id) |->
      (seg_id == (($past(seg_id) == 3'd5) ? 3'd0 : 3'($past(seg_id) + 3'd1))));

  a_r9_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(live_q) |-> (seg_start && seg_id == 3'd0 && bit_out));
endmodule

bind cid_pattern_gen cid_pattern_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_s_n),
  .en        (en),
  .bit_out   (bit_out),
  .seg_start (seg_start),
  .seg_id    (seg_id)
);

// File: tb/test_cid_pattern_gen.sv
`timescale 1ns/1ps
module test_cid_pattern_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic        cfg_wide;
  logic [15:0] cfg_rnd_len;
  logic [7:0]  cfg_trace;
  logic        cfg_free_run;
  logic [6:0]  cfg_seed;
  logic        bit_out, seg_start;
  logic [2:0]  seg_id;

  int n_checks = 0;
  int n_fail   = 0;

  // reference model state
  int         m_seg, m_cnt, m_len;
  logic [6:0] m_prbs, m_seed;
  logic       m_wide, m_free;
  logic [7:0] m_trace;
  int         e_bit, e_start, e_id;
  bit         last_en;

  always #2 clk = ~clk;

  cid_pattern_gen i_cid_pattern_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_wide(cfg_wide),
    .cfg_rnd_len(cfg_rnd_len), .cfg_trace(cfg_trace),
    .cfg_free_run(cfg_free_run), .cfg_seed(cfg_seed),
    .bit_out(bit_out), .seg_start(seg_start), .seg_id(seg_id)
  );

  task automatic chk(int got, int expv, string req, string what);
    n_checks++;
    if (got != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, expv);
    end
  endtask

  function automatic int oh_bit(logic wide, logic [7:0] tr, int idx);
    int nb = wide ? 192 : 48;
    int by = idx / 8;
    logic [7:0] v;
    if (by >= 2 * nb + nb / 3)      v = 8'hAA;
    else if (by > 2 * nb)           v = 8'hCC;
    else if (by == 2 * nb)          v = tr;
    else if (by >= nb)              v = 8'h28;
    else                            v = 8'hF6;
    return int'(v[7 - (idx % 8)]);
  endfunction

  function automatic int seg_length(int s);
    if (s == 0 || s == 3) return 72;
    if (s == 1 || s == 4) return m_len;
    return m_wide ? 24 * 192 : 24 * 48;
  endfunction

  task automatic model_reset();
    m_seg = 0; m_cnt = 0; m_prbs = 7'h7F;
    e_bit = 0; e_start = 0; e_id = 0;
  endtask

  // one enabled step of the reference (R1..R7, R10)
  task automatic model_step();
    if (m_seg == 0 && m_cnt == 0) begin  // R10: latch only here
      m_wide  = cfg_wide;
      m_len   = (cfg_rnd_len < 16'd2000) ? 2000 : int'(cfg_rnd_len);  // R4
      m_trace = cfg_trace;
      m_free  = cfg_free_run;
      m_seed  = (cfg_seed == 7'd0) ? 7'h7F : cfg_seed;                 // R7
    end
    case (m_seg)
      0: e_bit = 1;
      3: e_bit = 0;
      1, 4: begin
        if (!m_free && m_cnt == 0) m_prbs = m_seed;
        e_bit  = int'(m_prbs[6]);
        m_prbs = {m_prbs[5:0], m_prbs[6] ^ m_prbs[5]};
      end
      default: e_bit = oh_bit(m_wide, m_trace, m_cnt);
    endcase
    e_start = (m_cnt == 0) ? 1 : 0;
    e_id    = m_seg;
    m_cnt++;
    if (m_cnt == seg_length(m_seg)) begin
      m_cnt = 0;
      m_seg = (m_seg + 1) % 6;
    end
  endtask

  function automatic string bit_tag(int id, bit was_en);
    if (!was_en) return "R8";
    if (id == 0 || id == 3) return "R2";
    if (id == 1 || id == 4) return "R3/R4/R7/R10";
    return "R5/R6/R10";
  endfunction

  task automatic compare_outputs();
    chk(int'(bit_out), e_bit, bit_tag(e_id, last_en), "bit_out");
    chk(int'(seg_id), e_id, last_en ? "R1" : "R8", "seg_id");
    chk(int'(seg_start), e_start, last_en ? "R1" : "R8", "seg_start");
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    en    = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    // R9: outputs cleared during reset
    chk(int'(bit_out), 0, "R9", "reset bit_out");
    chk(int'(seg_start), 0, "R9", "reset seg_start");
    chk(int'(seg_id), 0, "R9", "reset seg_id");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    last_en = 1'b0;
  endtask

  // random enable; optional mid-run config change at cycle chg_at
  task automatic run(int cycles, int en_pct, int chg_at, logic c_wide,
                     logic [15:0] c_len, logic [7:0] c_tr, logic c_free,
                     logic [6:0] c_seed);
    for (int i = 0; i < cycles; i++) begin
      compare_outputs();
      if (i == chg_at) begin
        cfg_wide = c_wide; cfg_rnd_len = c_len; cfg_trace = c_tr;
        cfg_free_run = c_free; cfg_seed = c_seed;
      end
      en = (($urandom % 100) < en_pct);
      last_en = en;
      if (en) model_step();
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    cfg_wide = 1'b0; cfg_rnd_len = 16'd2000; cfg_trace = 8'h5A;
    cfg_free_run = 1'b1; cfg_seed = 7'h11;
    @(negedge clk);
    // phase 1: n=48, minimum length, free-running, then a mid-period change
    apply_reset();
    en = 1'b1; last_en = 1'b1; model_step();   // R9: first bit directed
    @(negedge clk);
    run(16000, 75, 5000, 1'b1, 16'd100, 8'hC3, 1'b0, 7'h00);
    // phase 2: n=192, fixed seed, short length clamped (R4, R7)
    apply_reset();
    run(30000, 90, 0, 1'b1, 16'd150, 8'h3C, 1'b0, 7'h00);
    // phase 3: odd length, explicit seed, switched back to free run mid-way
    apply_reset();
    cfg_wide = 1'b0; cfg_rnd_len = 16'd2003; cfg_trace = 8'hE7;
    cfg_free_run = 1'b0; cfg_seed = 7'h15;
    run(15000, 85, 7000, 1'b0, 16'd2500, 8'h81, 1'b1, 7'h2A);
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule